// File: doc/BRIEF.md
# Key-Guarded System Control Register Bank

This block holds a small set of system control registers on a simple register bus. The bus has a write strobe, a byte address, write data and a combinational read-data return. Some of the fields can change the power or reset behaviour of the whole chip, so a key gate guards them. Until software has written a fixed three-byte key to a dedicated unlock address, writes to the guarded fields are dropped without any error. Writing to the unlock address a second time closes the gate again.

The bank has three registers. The detector control register sets up an external supply-voltage detector. The power-on-reset disable code register holds a 16-bit code. The reset control register drives the reset requests: the chip-reset and CPU-reset requests are one-shot bits that clear themselves, and the bus-controller reset request stays asserted until software clears it. The detector comparator level and its crossing event come in as plain input bits. The analog circuits and the actual reset distribution sit outside this block.

The key gate is a four-state machine that advances only on writes to the unlock address. The state `ST_WAIT_K1` waits for the first key byte. `ST_WAIT_K2` and `ST_WAIT_K3` wait for the second and third key bytes. `ST_OPEN` means the guarded fields may be written.

The transitions are:
- `ST_WAIT_K1` goes to `ST_WAIT_K2` on 0x59.
- `ST_WAIT_K2` goes to `ST_WAIT_K3` on 0x16.
- `ST_WAIT_K3` goes to `ST_OPEN` on 0x88.
- Any other byte in a waiting state falls back to `ST_WAIT_K1`.
- Any write in `ST_OPEN` returns to `ST_WAIT_K1`.

A write to any other address leaves the state unchanged.

Top module: `sysctl_guard_regs`

## Requirements
- R1: After reset, every register field is 0 and every output is 0. Reading the unlock address (0x100) returns 0.
- R2: The gate opens after the bytes 0x59, 0x16 and 0x88 are written in that order to address 0x100, with the byte taken from write-data bits 7:0. From the next cycle, a read of 0x100 returns 1 in bit 0. That bit reads 0 while the gate is closed.
- R3: A wrong byte or an out-of-order byte written to 0x100 returns the sequence to its first step. Writes to other addresses between key bytes neither advance nor reset the sequence.
- R4: Any write to 0x100 while the gate is open closes it from the next cycle.
- R5: While the gate is closed, writes to guarded fields leave those fields and their outputs unchanged.
- R6: In the reset control register at 0x08, bit 0 is the chip-reset request and bit 1 is the CPU-reset request. Both are guarded. Writing 1 sets the bit in the next cycle, and the bit then stays high for exactly 2 cycles before clearing itself. Writing 1 again while the bit is high restarts the 2 cycles. Writing 0 has no effect.
- R7: Bit 3 of 0x08 is the guarded bus-controller reset request. It holds the last value written.
- R8: Bits 15:0 of 0x24 are a guarded code field. `por_disable` is high only while the field holds 0x5AA5.
- R9: The detector control register at 0x18 has this layout: bit 0 enable, bits 2:1 threshold, bit 3 reset-not-interrupt, bit 5 low power and bit 7 low-voltage-reset enable. All of these are guarded, read back, and drive their outputs.
- R10: Bit 6 of 0x18 reads `det_cmp_in` while the detector is enabled and reads 0 while it is disabled.
- R11: Bit 4 of 0x18 is the crossing flag. A `det_cross_pulse` sets it. Writing 1 to it clears it whatever the gate state. If a set and a clear happen in the same cycle, the set wins.
- R12: Unused bits read as 0. Writes to addresses other than 0x08, 0x18, 0x24 and 0x100 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| det_cmp_in | input | 1 | Detector comparator level (1 = supply below threshold) |
| det_cross_pulse | input | 1 | One-cycle threshold-crossing event |
| chip_rst_req | output | 1 | One-shot chip reset request |
| cpu_rst_req | output | 1 | One-shot CPU reset request |
| busctl_rst_req | output | 1 | Held bus-controller reset request |
| por_disable | output | 1 | Power-on-reset disable (code matches 0x5AA5) |
| det_en | output | 1 | Detector enable |
| det_level | output | 2 | Detector threshold select |
| det_rst_sel | output | 1 | Detector action: 1 = reset, 0 = interrupt |
| det_lowpwr | output | 1 | Detector low-power mode |
| lvr_en | output | 1 | Low-voltage-reset enable |

## Verification
Two cases can fall in the same cycle.

The first is a crossing pulse arriving in the same cycle as a software write-1-to-clear of the flag. The bench drives both at one clock edge and expects the flag to stay set.

The second is a guarded write made in the same cycle as the key write that closes the gate. This cannot happen, because the bus carries one address per cycle. The nearest case is a guarded write in the cycle right after the third key byte, which the bench expects to land, and one right after the closing write, which it expects to be dropped.

A rewrite of a one-shot bit while its pulse is still running is also driven. The bench expects the pulse to stretch to two cycles counted from the rewrite. A behavioural model compares every output and the read data on every clock.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    // Address map (byte offsets)
    localparam int OFS_RSTCTL = 'h008;
    localparam int OFS_DETCTL = 'h018;
    localparam int OFS_PORCODE = 'h024;
    localparam int OFS_KEY = 'h100;

    // Key bytes, in required order
    localparam logic [7:0] KEY_BYTE1 = 8'h59;
    localparam logic [7:0] KEY_BYTE2 = 8'h16;
    localparam logic [7:0] KEY_BYTE3 = 8'h88;

    localparam int CODE_W = 16;
    localparam logic [CODE_W-1:0] POR_OFF_CODE = 16'h5AA5;

    // Number of self-clearing reset request bits
    localparam int N_ONESHOT = 2;

    typedef enum logic [1:0] {
        ST_WAIT_K1 = 2'd0,
        ST_WAIT_K2 = 2'd1,
        ST_WAIT_K3 = 2'd2,
        ST_OPEN    = 2'd3
    } unlock_state_t;

    typedef struct packed {
        logic       lvr;
        logic       lowpwr;
        logic       rst_sel;
        logic [1:0] level;
        logic       en;
    } det_cfg_t;

endpackage

// File: rtl/sysctl_unlock_fsm.sv
module sysctl_unlock_fsm
    import sysctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_key,
    input  logic [7:0] key_byte,
    output logic       unlocked
);

    unlock_state_t st_q, st_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_WAIT_K1;
        else        st_q <= st_d;
    end

    // Next state: only writes to the key address move the machine
    always_comb begin
        st_d = st_q;
        if (wr_key) begin
            unique case (st_q)
                ST_WAIT_K1: st_d = (key_byte == KEY_BYTE1) ? ST_WAIT_K2 : ST_WAIT_K1;
                ST_WAIT_K2: st_d = (key_byte == KEY_BYTE2) ? ST_WAIT_K3 : ST_WAIT_K1;
                ST_WAIT_K3: st_d = (key_byte == KEY_BYTE3) ? ST_OPEN    : ST_WAIT_K1;
                ST_OPEN:    st_d = ST_WAIT_K1;
                default:    st_d = ST_WAIT_K1;
            endcase
        end
    end

    // Registered output aligned with the state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unlocked <= 1'b0;
        else        unlocked <= (st_d == ST_OPEN);
    end

endmodule

// File: rtl/sysctl_oneshot.sv
module sysctl_oneshot #(
    parameter int PULSE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);

    localparam int CW = $clog2(PULSE_CYCLES + 1);

    logic [CW-1:0] left_q;

    // Remaining high cycles; a new fire restarts the window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              left_q <= '0;
        else if (fire)           left_q <= CW'(PULSE_CYCLES);
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign pulse = (left_q != '0);

endmodule

// File: rtl/sysctl_guard_regs.sv
module sysctl_guard_regs
    import sysctl_pkg::*;
#(
    parameter int ADDR_W       = 9,
    parameter int DATA_W       = 32,
    parameter int PULSE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              det_cmp_in,
    input  logic              det_cross_pulse,
    output logic              chip_rst_req,
    output logic              cpu_rst_req,
    output logic              busctl_rst_req,
    output logic              por_disable,
    output logic              det_en,
    output logic [1:0]        det_level,
    output logic              det_rst_sel,
    output logic              det_lowpwr,
    output logic              lvr_en
);

    localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(OFS_RSTCTL);
    localparam logic [ADDR_W-1:0] A_DET  = ADDR_W'(OFS_DETCTL);
    localparam logic [ADDR_W-1:0] A_POR  = ADDR_W'(OFS_PORCODE);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(OFS_KEY);

    wire unused_wdata_hi = ^bus_wdata[DATA_W-1:CODE_W];

    // Address decode
    logic wr_rst, wr_det, wr_por, wr_key;
    assign wr_rst = bus_we && (bus_addr == A_RST);
    assign wr_det = bus_we && (bus_addr == A_DET);
    assign wr_por = bus_we && (bus_addr == A_POR);
    assign wr_key = bus_we && (bus_addr == A_KEY);

    // Key gate
    logic unlocked;
    sysctl_unlock_fsm u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_key   (wr_key),
        .key_byte (bus_wdata[7:0]),
        .unlocked (unlocked)
    );

    // Self-clearing reset requests: bit 0 chip, bit 1 CPU
    logic [N_ONESHOT-1:0] shot;
    for (genvar i = 0; i < N_ONESHOT; i++) begin : g_shot
        sysctl_oneshot #(.PULSE_CYCLES(PULSE_CYCLES)) u_shot (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (wr_rst && unlocked && bus_wdata[i]),
            .pulse (shot[i])
        );
    end
    assign chip_rst_req = shot[0];
    assign cpu_rst_req  = shot[1];

    // Held bus-controller reset request (bit 3)
    logic busctl_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   busctl_q <= 1'b0;
        else if (wr_rst && unlocked)  busctl_q <= bus_wdata[3];
    end
    assign busctl_rst_req = busctl_q;

    // Power-on-reset disable code
    logic [CODE_W-1:0] por_code_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   por_code_q <= '0;
        else if (wr_por && unlocked)  por_code_q <= bus_wdata[CODE_W-1:0];
    end
    assign por_disable = (por_code_q == POR_OFF_CODE);

    // Detector configuration (guarded fields)
    det_cfg_t cfg_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_det && unlocked) begin
            cfg_q.en      <= bus_wdata[0];
            cfg_q.level   <= bus_wdata[2:1];
            cfg_q.rst_sel <= bus_wdata[3];
            cfg_q.lowpwr  <= bus_wdata[5];
            cfg_q.lvr     <= bus_wdata[7];
        end
    end
    assign det_en      = cfg_q.en;
    assign det_level   = cfg_q.level;
    assign det_rst_sel = cfg_q.rst_sel;
    assign det_lowpwr  = cfg_q.lowpwr;
    assign lvr_en      = cfg_q.lvr;

    // Crossing flag: hardware set has priority over write-1-to-clear
    logic det_flag_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         det_flag_q <= 1'b0;
        else if (det_cross_pulse)           det_flag_q <= 1'b1;
        else if (wr_det && bus_wdata[4])    det_flag_q <= 1'b0;
    end

    logic cmp_seen;
    assign cmp_seen = det_cmp_in && cfg_q.en;

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RST: bus_rdata = DATA_W'({busctl_q, 1'b0, shot[1], shot[0]});
            A_DET: bus_rdata = DATA_W'({cfg_q.lvr, cmp_seen, cfg_q.lowpwr, det_flag_q,
                                        cfg_q.rst_sel, cfg_q.level, cfg_q.en});
            A_POR: bus_rdata = DATA_W'(por_code_q);
            A_KEY: bus_rdata = DATA_W'(unlocked);
            default: bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/sysctl_guard_regs_chk.sv
module sysctl_guard_regs_chk #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              det_cross_pulse,
    input logic              chip_rst_req,
    input logic              cpu_rst_req,
    input logic              busctl_rst_req,
    input logic              por_disable,
    input logic              det_en,
    input logic              unlocked,
    input logic              det_flag_q
);

    localparam logic [ADDR_W-1:0] A_RST = ADDR_W'('h008);
    localparam logic [ADDR_W-1:0] A_DET = ADDR_W'('h018);
    localparam logic [ADDR_W-1:0] A_POR = ADDR_W'('h024);
    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'('h100);

    logic mapped;
    assign mapped = (bus_addr == A_RST) || (bus_addr == A_DET) ||
                    (bus_addr == A_POR) || (bus_addr == A_KEY);

    // R6: a one-shot that rises stays high the following cycle
    p_chip_min_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chip_rst_req) |=> chip_rst_req);
    p_cpu_min_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_rst_req) |=> cpu_rst_req);
    // R6: a one-shot only falls after being high for two cycles
    p_chip_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chip_rst_req) |-> $past(chip_rst_req, 2));

    // R5: a closed gate keeps guarded state
    p_locked_por_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_POR && !unlocked) |=> $stable(por_disable));
    p_locked_busctl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_RST && !unlocked) |=> $stable(busctl_rst_req));
    p_locked_det_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DET && !unlocked) |=> $stable(det_en));

    // R4: any key write while open closes the gate
    p_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_KEY && unlocked) |=> !unlocked);

    // R10: comparator status hidden while detector disabled
    p_cmp_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DET && !det_en) |-> !bus_rdata[6]);

    // R11: crossing event always leaves the flag set
    p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        det_cross_pulse |=> det_flag_q);

    // R12: unmapped writes leave held state alone
    p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !mapped) |=> ($stable(por_disable) && $stable(busctl_rst_req) &&
                                 $stable(det_en) && $stable(unlocked)));

endmodule

bind sysctl_guard_regs sysctl_guard_regs_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_we          (bus_we),
    .bus_addr        (bus_addr),
    .bus_rdata       (bus_rdata),
    .det_cross_pulse (det_cross_pulse),
    .chip_rst_req    (chip_rst_req),
    .cpu_rst_req     (cpu_rst_req),
    .busctl_rst_req  (busctl_rst_req),
    .por_disable     (por_disable),
    .det_en          (det_en),
    .unlocked        (unlocked),
    .det_flag_q      (det_flag_q)
);

// File: tb/tb_sysctl_guard_regs.sv
`timescale 1ns/1ps
module tb_sysctl_guard_regs;

    localparam int AW = 9;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          det_cmp_in = 1'b0;
    logic          det_cross_pulse = 1'b0;
    logic          chip_rst_req, cpu_rst_req, busctl_rst_req, por_disable;
    logic          det_en, det_rst_sel, det_lowpwr, lvr_en;
    logic [1:0]    det_level;

    always #5 clk = ~clk;

    sysctl_guard_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .det_cmp_in(det_cmp_in),
        .det_cross_pulse(det_cross_pulse), .chip_rst_req(chip_rst_req),
        .cpu_rst_req(cpu_rst_req), .busctl_rst_req(busctl_rst_req),
        .por_disable(por_disable), .det_en(det_en), .det_level(det_level),
        .det_rst_sel(det_rst_sel), .det_lowpwr(det_lowpwr), .lvr_en(lvr_en)
    );

    int checks = 0;
    int failures = 0;
    bit compare_on = 0;
    bit finished = 0;

    // ---------------- behavioural reference model ----------------
    int  m_step;          // 0..2 key bytes matched, 3 = open
    int  m_chip_left, m_cpu_left;
    bit  m_busctl;
    int  m_code;
    bit  m_en, m_rsel, m_lp, m_lvr, m_flag;
    int  m_level;

    task automatic model_reset();
        m_step = 0; m_chip_left = 0; m_cpu_left = 0; m_busctl = 0; m_code = 0;
        m_en = 0; m_rsel = 0; m_lp = 0; m_lvr = 0; m_flag = 0; m_level = 0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            bit open_now;
            int a;
            int d;
            open_now = (m_step == 3);
            a = int'(bus_addr);
            d = int'(bus_wdata);
            if (m_chip_left > 0) m_chip_left--;
            if (m_cpu_left > 0)  m_cpu_left--;
            if (det_cross_pulse) m_flag = 1;
            else if (bus_we && a == 'h18 && d[4]) m_flag = 0;
            if (bus_we) begin
                if (a == 'h100) begin
                    if (open_now) m_step = 0;
                    else if (m_step == 0) m_step = ((d & 'hFF) == 'h59) ? 1 : 0;
                    else if (m_step == 1) m_step = ((d & 'hFF) == 'h16) ? 2 : 0;
                    else                  m_step = ((d & 'hFF) == 'h88) ? 3 : 0;
                end else if (open_now) begin
                    if (a == 'h08) begin
                        if (d[0]) m_chip_left = 2;
                        if (d[1]) m_cpu_left = 2;
                        m_busctl = d[3];
                    end else if (a == 'h24) begin
                        m_code = d & 'hFFFF;
                    end else if (a == 'h18) begin
                        m_en = d[0]; m_level = (d >> 1) & 3; m_rsel = d[3];
                        m_lp = d[5]; m_lvr = d[7];
                    end
                end
            end
        end
    end

    function automatic int exp_rdata(int a);
        case (a)
            'h08:  return (m_busctl ? 8 : 0) | (m_cpu_left > 0 ? 2 : 0) | (m_chip_left > 0 ? 1 : 0);
            'h18:  return (m_en ? 1 : 0) | (m_level << 1) | (m_rsel ? 8 : 0) | (m_flag ? 16 : 0) |
                          (m_lp ? 32 : 0) | ((m_en && det_cmp_in) ? 64 : 0) | (m_lvr ? 128 : 0);
            'h24:  return m_code;
            'h100: return (m_step == 3) ? 1 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_for(int a);
        case (a)
            'h08:  return "R6/R7";
            'h18:  return "R9/R10/R11";
            'h24:  return "R8";
            'h100: return "R2/R3/R4";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against model every cycle, away from the active edge
    always @(negedge clk) begin
        if (compare_on && !finished) begin
            chk("R6 chip_rst_req", int'(chip_rst_req), int'(m_chip_left > 0));
            chk("R6 cpu_rst_req", int'(cpu_rst_req), int'(m_cpu_left > 0));
            chk("R7 busctl_rst_req", int'(busctl_rst_req), int'(m_busctl));
            chk("R8 por_disable", int'(por_disable), int'(m_code == 'h5AA5));
            chk("R9 det outputs", int'({lvr_en, det_lowpwr, det_rst_sel, det_level, det_en}),
                (m_lvr ? 32 : 0) | (m_lp ? 16 : 0) | (m_rsel ? 8 : 0) | (m_level << 1) | (m_en ? 1 : 0));
            chk({tag_for(int'(bus_addr)), " rdata"}, int'(bus_rdata), exp_rdata(int'(bus_addr)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(int a, int d);
        @(posedge clk); #2;
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = DW'(d);
        @(posedge clk); #2;
        bus_we = 1'b0;
    endtask

    task automatic look(int a);
        @(posedge clk); #2;
        bus_addr = AW'(a);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    task automatic unlock();
        wr('h100, 'h59); wr('h100, 'h16); wr('h100, 'h88);
    endtask

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        #1 rst_n = 1'b1;
        idle(1);
        compare_on = 1;
        // R1: reset state
        chk("R1 outputs", int'({chip_rst_req, cpu_rst_req, busctl_rst_req, por_disable, det_en}), 0);
        look('h100); idle(1); chk("R1 key readback", int'(bus_rdata), 0);
        look('h18);  idle(1); chk("R1 det readback", int'(bus_rdata), 0);

        // R5: guarded writes dropped while closed
        wr('h24, 'h5AA5); wr('h18, 'hFF); wr('h08, 'h0B);
        idle(3);
        chk("R5 por held", int'(por_disable), 0);
        chk("R5 busctl held", int'(busctl_rst_req), 0);

        // R3: wrong and out-of-order keys
        wr('h100, 'h59); wr('h100, 'h88); look('h100); idle(1);
        chk("R3 skip byte", int'(bus_rdata), 0);
        wr('h100, 'h16); wr('h100, 'h59); wr('h100, 'h16); wr('h100, 'h59);
        idle(1); chk("R3 reorder", int'(bus_rdata), 0);
        // R3: writes elsewhere between key bytes keep the sequence
        wr('h100, 'h59); wr('h24, 'h1234); wr('h100, 'h16); wr('h0C, 'hFFFF); wr('h100, 'h88);
        look('h100); idle(1);
        chk("R2 open after key", int'(bus_rdata), 1);

        // R8 / R7 / R9 while open
        wr('h24, 'h5AA5); idle(1); chk("R8 code match", int'(por_disable), 1);
        wr('h24, 'h5AA4); idle(1); chk("R8 code miss", int'(por_disable), 0);
        wr('h24, 'h5AA5);
        wr('h08, 'h08); idle(2); chk("R7 busctl set", int'(busctl_rst_req), 1);
        wr('h18, 'hAF); look('h18); idle(1);
        chk("R9 det layout", int'(bus_rdata & 'hBF), 'hAF);

        // R6: one-shot lengths, rewrite restart, write-0 ignored
        wr('h08, 'h09); look('h08);
        idle(4);
        chk("R6 chip cleared", int'(chip_rst_req), 0);
        wr('h08, 'h0A); wr('h08, 'h0A); wr('h08, 'h08);
        idle(4);
        chk("R6 cpu cleared", int'(cpu_rst_req), 0);
        wr('h08, 'h00); idle(1); chk("R7 busctl cleared", int'(busctl_rst_req), 0);

        // R10: comparator gated by enable
        look('h18);
        det_cmp_in = 1'b1; idle(1); chk("R10 cmp seen", int'(bus_rdata[6]), 1);
        wr('h18, 'h00); idle(1); chk("R10 cmp hidden", int'(bus_rdata[6]), 0);
        det_cmp_in = 1'b0;

        // R12: unmapped writes
        wr('h10C, 'hFFFF_FFFF); wr('h01C, 'hFFFF_FFFF); look('h0C); idle(1);
        chk("R12 unmapped read", int'(bus_rdata), 0);

        // R4: relock, then guarded writes drop
        wr('h100, 'h00); look('h100); idle(1); chk("R4 relocked", int'(bus_rdata), 0);
        wr('h24, 'h0000); wr('h08, 'h01); idle(3);
        chk("R5 por after relock", int'(por_disable), 1);

        // R11: flag set, W1C while closed, same-cycle collision
        look('h18);
        @(posedge clk); #2; det_cross_pulse = 1'b1;
        @(posedge clk); #2; det_cross_pulse = 1'b0;
        idle(1); chk("R11 flag set", int'(bus_rdata[4]), 1);
        wr('h18, 'h10); look('h18); idle(1); chk("R11 flag cleared", int'(bus_rdata[4]), 0);
        det_cross_pulse = 1'b1; wr('h18, 'h10); det_cross_pulse = 1'b0;
        look('h18); idle(1); chk("R11 set beats clear", int'(bus_rdata[4]), 1);

        // Guarded write right after opening lands
        unlock(); wr('h18, 'h01); idle(1); chk("R2 write after open", int'(det_en), 1);
        wr('h100, 'h59); wr('h18, 'h00); idle(1); chk("R5 closed by key write", int'(det_en), 1);

        idle(3);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule